// File: doc/BRIEF.md
# Flash Command Port with Single-Entry Holding Stage

This block sits between firmware and the bank side of a multi-bank NAND flash controller. Firmware composes a command in a set of staging registers: an opcode, option flags, a target bank code, a buffer address and byte count for the data mover, column addresses, a copy-destination row, and a low/high row pair for every bank. Writing the launch register copies the whole composition into a one-entry holding stage. The staging registers are then free to be rewritten for the next command while the held one waits.

The holding stage hands its command to the bank side when the target bank offers to take it. A reserved bank code lets the hardware choose any idle bank, with the lowest-numbered one winning. An accepted bank counts as busy until it reports completion.

Firmware sees whether the holding stage is occupied, a sticky flag for launches that arrived while it was full, and a per-bank busy map. A cancel register discards a held command.

Top module: `flash_cmd_port`

## Requirements
- R1: After reset the status register (word address 10) and the busy register (word address 11) read zero, and no acceptance is signalled.
- R2: A write to the launch register (address 8) while the holding stage is empty copies the staged opcode (0), options (1), bank code (2, bits 5:0), buffer address (3), byte count (4), column (5), destination column (6) and destination row (7) into the holding stage. Status bit 0 reads 1 from the next cycle. Later staging writes do not alter the held command.
- R3: A launch write while status bit 0 is 1 leaves the held command unchanged and sets status bit 1. This flag stays set until firmware writes the status register with data bit 1 set.
- R4: With an explicit bank code below the bank count, the held command is accepted only in a cycle where that bank's ready input is high and the bank is not busy. In that cycle acc_valid is high and acc_bank and the descriptor outputs carry the command. Status bit 0 reads 0 from the next cycle.
- R5: Bank code 0x3F selects automatic placement: the command goes to the lowest-numbered bank whose ready input is high and which is not busy.
- R6: An accepted bank reads busy (busy register bit n for bank n) from the cycle after acceptance until the cycle after its done input pulses. While it is busy its ready input is ignored.
- R7: A write to the cancel register (address 9) empties the holding stage. In the same cycle it suppresses any acceptance.
- R8: The row pair delivered with an acceptance is the low/high pair staged for the accepted bank at launch time. Row registers sit at word address 0x40 + 2*bank + h, where h=0 is low and h=1 is high.
- R9: A bank code that is neither 0x3F nor below the bank count is never accepted. The command stays held until cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | ADDR_W | Status read word address |
| rd_data | output | 32 | Status read data (combinational) |
| bank_ready | input | NUM_BANKS | Per-bank offer to take a command |
| bank_done | input | NUM_BANKS | Per-bank completion pulse |
| acc_valid | output | 1 | Acceptance in this cycle |
| acc_bank | output | $clog2(NUM_BANKS) | Accepting bank |
| acc_cmd | output | 32 | Accepted opcode |
| acc_opt | output | 32 | Accepted option flags |
| acc_dma_addr | output | 32 | Accepted buffer address |
| acc_dma_cnt | output | 32 | Accepted byte count |
| acc_col | output | 32 | Accepted column |
| acc_dst_col | output | 32 | Accepted destination column |
| acc_dst_row | output | 32 | Accepted destination row |
| acc_row_lo | output | 32 | Low row for the accepting bank |
| acc_row_hi | output | 32 | High row for the accepting bank |

## Verification
The assertions assume that a bank pulses done only while it is busy. They also assume that the bank side treats a ready input as an offer that costs nothing when it is not taken. The stimulus pulses done exactly once per accepted command, and only for the bank reported on acc_bank. It drops every ready input right after each handshake. It also issues only one register write per cycle, so a launch and a cancel never coincide; the holding-stage assertions rely on that.

// File: rtl/fcp_pkg.sv
package fcp_pkg;
    localparam int FCP_DW     = 32;
    localparam int FCP_BANK_W = 6;
    localparam logic [FCP_BANK_W-1:0] FCP_AUTO_BANK = 6'h3F;

    // word addresses of the register window
    localparam int REG_CMD      = 0;
    localparam int REG_OPT      = 1;
    localparam int REG_BANK     = 2;
    localparam int REG_DMA_ADDR = 3;
    localparam int REG_DMA_CNT  = 4;
    localparam int REG_COL      = 5;
    localparam int REG_DST_COL  = 6;
    localparam int REG_DST_ROW  = 7;
    localparam int REG_LAUNCH   = 8;
    localparam int REG_CANCEL   = 9;
    localparam int REG_STATUS   = 10;
    localparam int REG_BUSY     = 11;
    localparam int REG_ROW_BASE = 64;

    typedef struct packed {
        logic [FCP_DW-1:0]     cmd;
        logic [FCP_DW-1:0]     opt;
        logic [FCP_DW-1:0]     dma_addr;
        logic [FCP_DW-1:0]     dma_cnt;
        logic [FCP_DW-1:0]     col;
        logic [FCP_DW-1:0]     dst_col;
        logic [FCP_DW-1:0]     dst_row;
        logic [FCP_BANK_W-1:0] bank;
    } fcp_desc_t;
endpackage

// File: rtl/fcp_stage_regs.sv
module fcp_stage_regs
    import fcp_pkg::*;
#(
    parameter int NUM_BANKS = 32,
    parameter int ADDR_W    = 7
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [ADDR_W-1:0]                     wr_addr,
    input  logic [FCP_DW-1:0]                     wr_data,
    output fcp_desc_t                             stage_desc,
    output logic [NUM_BANKS-1:0][1:0][FCP_DW-1:0] stage_rows,
    output logic                                  launch,
    output logic                                  cancel,
    output logic                                  ovf_clr
);
    typedef struct packed {
        fcp_desc_t                             desc;
        logic [NUM_BANKS-1:0][1:0][FCP_DW-1:0] rows;
    } stage_t;

    stage_t st_d, st_q;
    int     row_idx;

    always_comb begin
        st_d    = st_q;
        row_idx = int'(wr_addr[ADDR_W-2:1]);
        launch  = wr_en && (int'(wr_addr) == REG_LAUNCH);
        cancel  = wr_en && (int'(wr_addr) == REG_CANCEL);
        ovf_clr = wr_en && (int'(wr_addr) == REG_STATUS) && wr_data[1];
        if (wr_en) begin
            if (wr_addr[ADDR_W-1]) begin
                if (row_idx < NUM_BANKS)
                    st_d.rows[row_idx][wr_addr[0]] = wr_data;
            end else begin
                case (int'(wr_addr))
                    REG_CMD:      st_d.desc.cmd      = wr_data;
                    REG_OPT:      st_d.desc.opt      = wr_data;
                    REG_BANK:     st_d.desc.bank     = wr_data[FCP_BANK_W-1:0];
                    REG_DMA_ADDR: st_d.desc.dma_addr = wr_data;
                    REG_DMA_CNT:  st_d.desc.dma_cnt  = wr_data;
                    REG_COL:      st_d.desc.col      = wr_data;
                    REG_DST_COL:  st_d.desc.dst_col  = wr_data;
                    REG_DST_ROW:  st_d.desc.dst_row  = wr_data;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stage_desc = st_q.desc;
    assign stage_rows = st_q.rows;
endmodule

// File: rtl/fcp_wait_room.sv
module fcp_wait_room
    import fcp_pkg::*;
#(
    parameter int NUM_BANKS = 32
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  launch,
    input  logic                                  cancel,
    input  logic                                  ovf_clr,
    input  logic                                  take,
    input  fcp_desc_t                             stage_desc,
    input  logic [NUM_BANKS-1:0][1:0][FCP_DW-1:0] stage_rows,
    output logic                                  room_valid,
    output fcp_desc_t                             room_desc,
    output logic [NUM_BANKS-1:0][1:0][FCP_DW-1:0] room_rows,
    output logic                                  ovf
);
    typedef struct packed {
        logic                                  valid;
        logic                                  ovf;
        fcp_desc_t                             desc;
        logic [NUM_BANKS-1:0][1:0][FCP_DW-1:0] rows;
    } room_t;

    room_t rm_d, rm_q;

    always_comb begin
        rm_d = rm_q;
        if (ovf_clr)             rm_d.ovf   = 1'b0;
        if (cancel || take)      rm_d.valid = 1'b0;
        if (launch) begin
            if (rm_q.valid) begin
                rm_d.ovf = 1'b1;
            end else begin
                rm_d.valid = 1'b1;
                rm_d.desc  = stage_desc;
                rm_d.rows  = stage_rows;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rm_q <= '0;
        else        rm_q <= rm_d;
    end

    assign room_valid = rm_q.valid;
    assign room_desc  = rm_q.desc;
    assign room_rows  = rm_q.rows;
    assign ovf        = rm_q.ovf;

    // R2: a launch into an empty stage captures the staged descriptor
    p_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        launch && !room_valid |=> room_valid && room_desc == $past(stage_desc));
    // R3: a launch into a full stage only raises the flag
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        launch && room_valid |=> ovf && $stable(room_desc));
    // R7: cancel always empties the stage
    p_cancel_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |=> !room_valid);
    // R4: an accepted command leaves the stage
    p_take_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !room_valid);
endmodule

// File: rtl/fcp_bank_pick.sv
module fcp_bank_pick
    import fcp_pkg::*;
#(
    parameter int NUM_BANKS = 32,
    localparam int BW = $clog2(NUM_BANKS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  room_valid,
    input  logic [FCP_BANK_W-1:0] room_bank,
    input  logic                  cancel,
    input  logic [NUM_BANKS-1:0]  bank_ready,
    input  logic [NUM_BANKS-1:0]  bank_done,
    output logic                  take,
    output logic [BW-1:0]         take_bank,
    output logic [NUM_BANKS-1:0]  busy
);
    typedef struct packed {
        logic [NUM_BANKS-1:0] busy;
    } pick_t;

    pick_t                pk_d, pk_q;
    logic [NUM_BANKS-1:0] idle;
    logic                 found;

    always_comb begin
        pk_d      = pk_q;
        idle      = bank_ready & ~pk_q.busy;
        found     = 1'b0;
        take_bank = '0;
        if (room_bank == FCP_AUTO_BANK) begin
            for (int i = NUM_BANKS - 1; i >= 0; i--) begin
                if (idle[i]) begin
                    found     = 1'b1;
                    take_bank = BW'(i);
                end
            end
        end else if (int'(room_bank) < NUM_BANKS) begin
            take_bank = room_bank[BW-1:0];
            found     = idle[take_bank];
        end
        take = room_valid && found && !cancel;
        pk_d.busy = pk_q.busy & ~bank_done;
        if (take) pk_d.busy[take_bank] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign busy = pk_q.busy;

    // R4: acceptance only by a bank that offers and is idle
    p_take_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> bank_ready[take_bank] && !busy[take_bank]);
    // R5: automatic placement picks the lowest idle offering bank
    p_auto_lowest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take && room_bank == FCP_AUTO_BANK |->
            ((bank_ready & ~busy) & ((NUM_BANKS'(1) << take_bank) - NUM_BANKS'(1))) == '0);
    // R6: accepted bank turns busy
    p_busy_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> busy[$past(take_bank)]);
    // R6: busy drops only on done
    p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (($past(busy) & ~$past(bank_done) & ~busy) == '0));
    // R6: input rule, done only from a busy bank
    p_done_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_done & ~busy) == '0);
    // R9: codes naming no bank are never accepted
    p_bad_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        room_valid && room_bank != FCP_AUTO_BANK && int'(room_bank) >= NUM_BANKS |-> !take);
    // R7: cancel suppresses acceptance
    p_cancel_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |-> !take);
endmodule

// File: rtl/flash_cmd_port.sv
module flash_cmd_port
    import fcp_pkg::*;
#(
    parameter int NUM_BANKS = 32,
    parameter int ADDR_W    = 7,
    localparam int BW = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [FCP_DW-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [FCP_DW-1:0]    rd_data,
    input  logic [NUM_BANKS-1:0] bank_ready,
    input  logic [NUM_BANKS-1:0] bank_done,
    output logic                 acc_valid,
    output logic [BW-1:0]        acc_bank,
    output logic [FCP_DW-1:0]    acc_cmd,
    output logic [FCP_DW-1:0]    acc_opt,
    output logic [FCP_DW-1:0]    acc_dma_addr,
    output logic [FCP_DW-1:0]    acc_dma_cnt,
    output logic [FCP_DW-1:0]    acc_col,
    output logic [FCP_DW-1:0]    acc_dst_col,
    output logic [FCP_DW-1:0]    acc_dst_row,
    output logic [FCP_DW-1:0]    acc_row_lo,
    output logic [FCP_DW-1:0]    acc_row_hi
);
    fcp_desc_t                             stage_desc, room_desc;
    logic [NUM_BANKS-1:0][1:0][FCP_DW-1:0] stage_rows, room_rows;
    logic                                  launch, cancel, ovf_clr;
    logic                                  room_valid, ovf, take;
    logic [BW-1:0]                         take_bank;
    logic [NUM_BANKS-1:0]                  busy;

    fcp_stage_regs #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_stage (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .stage_desc(stage_desc), .stage_rows(stage_rows),
        .launch(launch), .cancel(cancel), .ovf_clr(ovf_clr)
    );

    fcp_wait_room #(.NUM_BANKS(NUM_BANKS)) u_room (
        .clk(clk), .rst_n(rst_n), .launch(launch), .cancel(cancel),
        .ovf_clr(ovf_clr), .take(take), .stage_desc(stage_desc),
        .stage_rows(stage_rows), .room_valid(room_valid),
        .room_desc(room_desc), .room_rows(room_rows), .ovf(ovf)
    );

    fcp_bank_pick #(.NUM_BANKS(NUM_BANKS)) u_pick (
        .clk(clk), .rst_n(rst_n), .room_valid(room_valid),
        .room_bank(room_desc.bank), .cancel(cancel),
        .bank_ready(bank_ready), .bank_done(bank_done),
        .take(take), .take_bank(take_bank), .busy(busy)
    );

    always_comb begin
        case (int'(rd_addr))
            REG_STATUS: rd_data = {{(FCP_DW-2){1'b0}}, ovf, room_valid};
            REG_BUSY:   rd_data = FCP_DW'(busy);
            default:    rd_data = '0;
        endcase
    end

    assign acc_valid    = take;
    assign acc_bank     = take_bank;
    assign acc_cmd      = room_desc.cmd;
    assign acc_opt      = room_desc.opt;
    assign acc_dma_addr = room_desc.dma_addr;
    assign acc_dma_cnt  = room_desc.dma_cnt;
    assign acc_col      = room_desc.col;
    assign acc_dst_col  = room_desc.dst_col;
    assign acc_dst_row  = room_desc.dst_row;
    assign acc_row_lo   = room_rows[take_bank][0];
    assign acc_row_hi   = room_rows[take_bank][1];

    // R1: no acceptance from an empty stage
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !room_valid |-> !acc_valid);
    // R6: busy map seen at the status port matches the picker
    p_busy_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rd_addr) == REG_BUSY |-> rd_data == FCP_DW'(busy));
endmodule

// File: tb/flash_cmd_port_bench.sv
module flash_cmd_port_bench;
    import fcp_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 32;

    typedef struct packed {
        logic [5:0]  code;
        logic [31:0] ready;
        logic        exp_take;
        logic [4:0]  exp_bank;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{6'd3,  32'hFFFF_FFFF, 1'b1, 5'd3},
        '{6'h3F, 32'hFFFF_FFFF, 1'b1, 5'd0},
        '{6'h3F, 32'h0000_00F0, 1'b1, 5'd4},
        '{6'd31, 32'h8000_0000, 1'b1, 5'd31},
        '{6'd5,  32'hFFFF_FFDF, 1'b0, 5'd0},
        '{6'h3F, 32'h8000_0000, 1'b1, 5'd31},
        '{6'h3F, 32'h0000_0000, 1'b0, 5'd0},
        '{6'd40, 32'hFFFF_FFFF, 1'b0, 5'd0}
    };

    logic clk = 0, rst_n = 0, wr_en = 0;
    logic [6:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0, rd_data;
    logic [NB-1:0] bank_ready = '0, bank_done = '0;
    logic acc_valid;
    logic [4:0] acc_bank;
    logic [31:0] acc_cmd, acc_opt, acc_dma_addr, acc_dma_cnt, acc_col;
    logic [31:0] acc_dst_col, acc_dst_row, acc_row_lo, acc_row_hi;
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_port u_flash_cmd_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .bank_ready(bank_ready), .bank_done(bank_done),
        .acc_valid(acc_valid), .acc_bank(acc_bank), .acc_cmd(acc_cmd),
        .acc_opt(acc_opt), .acc_dma_addr(acc_dma_addr),
        .acc_dma_cnt(acc_dma_cnt), .acc_col(acc_col),
        .acc_dst_col(acc_dst_col), .acc_dst_row(acc_dst_row),
        .acc_row_lo(acc_row_lo), .acc_row_hi(acc_row_hi)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, the write lands at the next rising edge
    task automatic wr(input int addr, input logic [31:0] data);
        wr_en = 1; wr_addr = 7'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        rd_addr = 7'(addr);
        #1 data = rd_data;
    endtask

    task automatic finish_bank(input int b);
        bank_done = NB'(1) << b;
        @(negedge clk);
        bank_done = '0;
    endtask

    initial begin
        logic [31:0] v;
        string tag;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd(REG_STATUS, v); chk("R1 status", v, 0);
        rd(REG_BUSY, v);   chk("R1 busy", v, 0);
        chk("R1 acc_valid", 32'(acc_valid), 0);

        // table walk: R4 explicit, R5 automatic, R9 invalid code
        foreach (VECS[i]) begin
            tag = (VECS[i].code == 6'h3F) ? "R5" : (VECS[i].code >= 6'd32) ? "R9" : "R4";
            wr(REG_CMD, 32'hA0 + i);
            wr(REG_BANK, 32'(VECS[i].code));
            wr(REG_LAUNCH, 0);
            bank_ready = VECS[i].ready;
            #1;
            chk({tag, " take"}, 32'(acc_valid), 32'(VECS[i].exp_take));
            if (VECS[i].exp_take) begin
                chk({tag, " bank"}, 32'(acc_bank), 32'(VECS[i].exp_bank));
                chk({tag, " cmd"}, acc_cmd, 32'hA0 + i);
            end
            @(negedge clk);
            bank_ready = '0;
            if (VECS[i].exp_take) begin
                rd(REG_STATUS, v); chk({tag, " stage emptied"}, v, 0);
                rd(REG_BUSY, v); chk("R6 busy after take", v, 32'(1) << VECS[i].exp_bank);
                finish_bank(VECS[i].exp_bank);
            end else begin
                rd(REG_STATUS, v); chk({tag, " still held"}, v, 1);
                wr(REG_CANCEL, 0);
            end
        end

        // R2 / R8: full descriptor and per-bank rows, staging reuse
        wr(REG_CMD, 32'h11); wr(REG_OPT, 32'h22); wr(REG_DMA_ADDR, 32'h1000);
        wr(REG_DMA_CNT, 32'h200); wr(REG_COL, 32'h8); wr(REG_DST_COL, 32'h9);
        wr(REG_DST_ROW, 32'h77); wr(REG_BANK, 32'h3F);
        wr(REG_ROW_BASE + 8, 32'h1234); wr(REG_ROW_BASE + 9, 32'h5678);
        wr(REG_ROW_BASE + 0, 32'hDEAD);
        wr(REG_LAUNCH, 0);
        rd(REG_STATUS, v); chk("R2 held bit", v, 1);
        wr(REG_CMD, 32'h99); wr(REG_ROW_BASE + 8, 32'hFFFF);
        bank_ready = NB'(1) << 4;
        #1;
        chk("R5 auto bank", 32'(acc_bank), 4);
        chk("R2 cmd kept", acc_cmd, 32'h11);
        chk("R2 opt", acc_opt, 32'h22);
        chk("R2 dma addr", acc_dma_addr, 32'h1000);
        chk("R2 dma cnt", acc_dma_cnt, 32'h200);
        chk("R2 col", acc_col, 32'h8);
        chk("R2 dst col", acc_dst_col, 32'h9);
        chk("R2 dst row", acc_dst_row, 32'h77);
        chk("R8 row lo", acc_row_lo, 32'h1234);
        chk("R8 row hi", acc_row_hi, 32'h5678);
        @(negedge clk); bank_ready = '0;
        finish_bank(4);

        // R3 overflow: second launch ignored
        wr(REG_BANK, 2);
        wr(REG_LAUNCH, 0);
        wr(REG_CMD, 32'h55);
        wr(REG_LAUNCH, 0);
        rd(REG_STATUS, v); chk("R3 flag set", v, 3);
        bank_ready = '1;
        #1;
        chk("R3 first kept", acc_cmd, 32'h99);
        @(negedge clk); bank_ready = '0;
        finish_bank(2);
        rd(REG_STATUS, v); chk("R3 flag sticky", v, 2);
        wr(REG_STATUS, 2);
        rd(REG_STATUS, v); chk("R3 flag cleared", v, 0);

        // R6 busy bank refuses until done
        wr(REG_BANK, 1);
        wr(REG_LAUNCH, 0);
        bank_ready = NB'(1) << 1;
        #1 chk("R6 first take", 32'(acc_valid), 1);
        @(negedge clk); bank_ready = '0;
        wr(REG_LAUNCH, 0);
        bank_ready = NB'(1) << 1;
        #1 chk("R6 refused while busy", 32'(acc_valid), 0);
        rd(REG_BUSY, v); chk("R6 busy bit", v, 2);
        bank_done = NB'(1) << 1;
        @(negedge clk); bank_done = '0;
        #1 chk("R6 taken after done", 32'(acc_valid), 1);
        @(negedge clk); bank_ready = '0;
        finish_bank(1);

        // R7 cancel
        wr(REG_BANK, 6);
        wr(REG_LAUNCH, 0);
        wr(REG_CANCEL, 0);
        rd(REG_STATUS, v); chk("R7 cancelled", v, 0);
        bank_ready = '1;
        #1 chk("R7 nothing to take", 32'(acc_valid), 0);
        @(negedge clk); bank_ready = '0;
        wr(REG_LAUNCH, 0);
        bank_ready = NB'(1) << 6;
        wr_en = 1; wr_addr = 7'(REG_CANCEL);
        #1 chk("R7 cancel beats take", 32'(acc_valid), 0);
        @(negedge clk); wr_en = 0; bank_ready = '0;
        rd(REG_BUSY, v); chk("R7 no busy", v, 0);
        rd(REG_STATUS, v); chk("R7 stage empty", v, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule